// File: doc/BRIEF.md
# Banked GPIO Edge-Detect Interrupt Unit

This block monitors a set of general-purpose input pins, split into banks of 32, and records level changes on them as sticky status bits. Each pin has its own rising and falling detect enables, a direction bit and an interrupt mask. Software reaches every register over a simple single-cycle register bus. The address's upper bits select the bank, and its low byte selects the register.

Each pin input passes through a two-flop synchronizer. An edge is a difference between the two most recent synchronized samples, and it is seen only while the pin is configured as an input. When an enabled edge occurs, the pin's status bit sets and stays set until software writes a 1 to that bit.

Masked status drives three level-sensitive interrupt lines. Pin 0 has its own line and pin 1 has its own line. All remaining pins share one OR-ed line.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads zero: direction (all pins are inputs), rising enable, falling enable, status and mask. All three interrupt outputs are low.
- R2: The bank number is `addr[9:8]` and the register is `addr[7:0]`. Bit n of a bank's register belongs to pin 32*bank+n. The offsets are: 0x0C direction readback, 0x30 rising enable, 0x3C falling enable, 0x48 status, 0x54 direction set, 0x60 direction clear, 0xA8 mask. A write touches only the addressed bank's register.
- R3: In the direction readback, 1 means output and 0 means input. Writing 1 to a bit at 0x54 makes that pin an output. Writing 1 to a bit at 0x60 makes that pin an input. Writing 0 to either register leaves the pin's direction unchanged.
- R4: With its rising enable at 1, a 0-to-1 change on an input pin sets the pin's status bit. Count the first clock edge at which the new pin level is present as edge 1. The status bit is still 0 after edge 2 and reads 1 after edge 3.
- R5: With its falling enable at 1, a 1-to-0 change on an input pin sets the pin's status bit with the same timing as R4. When both enables are 1, either direction of change sets the bit.
- R6: A change whose direction has its enable at 0 leaves the status bit unchanged.
- R7: Status bits are sticky. Writing 1 to a bit at 0x48 clears that bit, and writing 0 leaves it unchanged.
- R8: If an enabled edge and a clearing write for the same bit fall on the same clock edge, the bit ends up set.
- R9: A mask bit of 0 keeps the pin's status out of every interrupt line, but the status bit still sets.
- R10: Each interrupt line is a level: it is the OR of (status AND mask) over the pins it serves. `irq_pin0` serves pin 0, `irq_pin1` serves pin 1, and `irq_shared` serves pins 2 through 127.
- R11: A pin whose direction bit is 1 (output) never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 128 | Asynchronous pin levels |
| addr | input | 10 | Register address: bank in [9:8], offset in [7:0] |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Shared interrupt for pins 2..127 |

## Verification
The assertions assume that a write is a one-cycle strobe whose address and data are steady around the clock edge. They also assume that a pin changes level no more often than every few cycles, so each transition shows up as exactly one synchronized edge. The bench drives the bus and the pins only on falling clock edges and leaves each pin level in place for several cycles before the next change. It places the coinciding set and clear on purpose, by counting clock edges from the pin change.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int BANKS = 4,
  parameter int AW    = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANKS*32-1:0]   pin_in,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  input  logic                  we,
  output logic [31:0]           rdata,
  output logic                  irq_pin0,
  output logic                  irq_pin1,
  output logic                  irq_shared
);
  localparam int NP = BANKS * 32;
  localparam int BW = AW - 8;
  localparam logic [7:0] OFF_DIR  = 8'h0C;
  localparam logic [7:0] OFF_REN  = 8'h30;
  localparam logic [7:0] OFF_FEN  = 8'h3C;
  localparam logic [7:0] OFF_EDR  = 8'h48;
  localparam logic [7:0] OFF_DSET = 8'h54;
  localparam logic [7:0] OFF_DCLR = 8'h60;
  localparam logic [7:0] OFF_MSK  = 8'hA8;

  logic [NP-1:0] s0, s1, s2;
  logic [NP-1:0] dir, ren, fen, msk, stat;

  wire [BW-1:0] bsel = addr[AW-1:8];
  wire [7:0]    off  = addr[7:0];

  logic [NP-1:0] bsv;
  wire  [NP-1:0] wrep = {BANKS{wdata}};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bsv[b*32 +: 32] = {32{we && (bsel == BW'(b))}};
  end

  wire [NP-1:0] sel_ren  = (off == OFF_REN)  ? bsv : '0;
  wire [NP-1:0] sel_fen  = (off == OFF_FEN)  ? bsv : '0;
  wire [NP-1:0] sel_msk  = (off == OFF_MSK)  ? bsv : '0;
  wire [NP-1:0] clr_vec  = (off == OFF_EDR)  ? (bsv & wrep) : '0;
  wire [NP-1:0] dset_vec = (off == OFF_DSET) ? (bsv & wrep) : '0;
  wire [NP-1:0] dclr_vec = (off == OFF_DCLR) ? (bsv & wrep) : '0;

  wire [NP-1:0] rise = s1 & ~s2 & ren & ~dir;
  wire [NP-1:0] fall = ~s1 & s2 & fen & ~dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0 <= '0; s1 <= '0; s2 <= '0;
      dir <= '0; ren <= '0; fen <= '0; msk <= '0; stat <= '0;
    end else begin
      s0   <= pin_in;
      s1   <= s0;
      s2   <= s1;
      ren  <= (ren & ~sel_ren) | (wrep & sel_ren);
      fen  <= (fen & ~sel_fen) | (wrep & sel_fen);
      msk  <= (msk & ~sel_msk) | (wrep & sel_msk);
      dir  <= (dir | dset_vec) & ~dclr_vec;
      stat <= (stat & ~clr_vec) | rise | fall;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (int'(bsel) == b) begin
        case (off)
          OFF_DIR: rdata = dir[b*32 +: 32];
          OFF_REN: rdata = ren[b*32 +: 32];
          OFF_FEN: rdata = fen[b*32 +: 32];
          OFF_EDR: rdata = stat[b*32 +: 32];
          OFF_MSK: rdata = msk[b*32 +: 32];
          default: rdata = '0;
        endcase
      end
    end
  end

  wire [NP-1:0] act = stat & msk;
  assign irq_pin0   = act[0];
  assign irq_pin1   = act[1];
  assign irq_shared = |act[NP-1:2];

  // R7
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat & ~clr_vec) & ~stat) == '0));

  // R11
  output_no_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & $past(dir)) == '0));

  // R6
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~($past(ren) | $past(fen))) == '0));

  // R3
  dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclr_vec != '0) |=> ((dir & $past(dclr_vec)) == '0));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '0) |-> (!irq_pin0 && !irq_pin1 && !irq_shared));
endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] pins = '0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0;
  logic [31:0] rdata;
  logic irq_pin0, irq_pin1, irq_shared;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .addr(addr), .wdata(wdata),
    .we(we), .rdata(rdata), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
    .irq_shared(irq_shared)
  );

  localparam logic [7:0] DIR = 8'h0C, REN = 8'h30, FEN = 8'h3C, EDR = 8'h48,
                         DSET = 8'h54, DCLR = 8'h60, MSK = 8'hA8;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int bank, input logic [7:0] off, input logic [31:0] d);
    addr = {bank[1:0], off}; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string tag, input int bank, input logic [7:0] off, input logic [31:0] exp);
    addr = {bank[1:0], off};
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int b = 0; b < 4; b++) begin
      rd("R1 dir", b, DIR, 0); rd("R1 ren", b, REN, 0); rd("R1 fen", b, FEN, 0);
      rd("R1 edr", b, EDR, 0); rd("R1 msk", b, MSK, 0);
    end
    chk("R1 irqs", {29'd0, irq_pin0, irq_pin1, irq_shared}, 0);
  endtask

  task automatic t_map();
    wr(2, REN, 32'hA5A5_0001);
    wr(1, FEN, 32'h0000_F00F);
    wr(3, MSK, 32'h8000_0010);
    rd("R2 ren bank2", 2, REN, 32'hA5A5_0001);
    rd("R2 ren bank0 untouched", 0, REN, 0);
    rd("R2 fen bank1", 1, FEN, 32'h0000_F00F);
    rd("R2 fen bank2 untouched", 2, FEN, 0);
    rd("R2 msk bank3", 3, MSK, 32'h8000_0010);
    for (int b = 0; b < 4; b++) begin
      wr(b, REN, 0); wr(b, FEN, 0); wr(b, MSK, 0);
    end
  endtask

  task automatic t_dir();
    wr(0, DSET, 32'h0000_00F0);
    rd("R3 set", 0, DIR, 32'h0000_00F0);
    rd("R3 other bank", 1, DIR, 0);
    wr(0, DSET, 0);
    rd("R3 set zero no effect", 0, DIR, 32'h0000_00F0);
    wr(0, DCLR, 32'h0000_0030);
    rd("R3 clear", 0, DIR, 32'h0000_00C0);
    wr(0, DCLR, 0);
    rd("R3 clear zero no effect", 0, DIR, 32'h0000_00C0);
    wr(0, DCLR, 32'hFFFF_FFFF);
    rd("R3 all inputs", 0, DIR, 0);
  endtask

  task automatic t_rise();
    wr(0, REN, 32'h0000_0020);
    pins[5] = 1'b1;
    repeat (2) @(negedge clk);
    rd("R4 not yet after edge 2", 0, EDR, 0);
    @(negedge clk);
    rd("R4 set after edge 3", 0, EDR, 32'h0000_0020);
    pins[5] = 1'b0; settle();
    rd("R6 fall ignored when only rise enabled", 0, EDR, 32'h0000_0020);
  endtask

  task automatic t_w1c();
    wr(0, EDR, 0);
    rd("R7 write 0 no effect", 0, EDR, 32'h0000_0020);
    wr(0, EDR, 32'hFFFF_FFDF);
    rd("R7 other ones no effect", 0, EDR, 32'h0000_0020);
    wr(0, EDR, 32'h0000_0020);
    rd("R7 cleared", 0, EDR, 0);
    wr(0, REN, 0);
  endtask

  task automatic t_fall();
    wr(1, FEN, 32'h0000_0008);
    pins[35] = 1'b1; settle();
    rd("R6 rise ignored when only fall enabled", 1, EDR, 0);
    pins[35] = 1'b0;
    repeat (2) @(negedge clk);
    rd("R5 not yet after edge 2", 1, EDR, 0);
    @(negedge clk);
    rd("R5 fall set", 1, EDR, 32'h0000_0008);
    wr(1, EDR, 32'h0000_0008); wr(1, FEN, 0);
  endtask

  task automatic t_both();
    wr(2, REN, 32'h40); wr(2, FEN, 32'h40);
    pins[70] = 1'b1; settle();
    rd("R5 both rise", 2, EDR, 32'h40);
    wr(2, EDR, 32'h40);
    rd("R7 clear between", 2, EDR, 0);
    pins[70] = 1'b0; settle();
    rd("R5 both fall", 2, EDR, 32'h40);
    wr(2, EDR, 32'h40);
  endtask

  task automatic t_setwins();
    pins[70] = 1'b1; settle();
    rd("R8 preset", 2, EDR, 32'h40);
    pins[70] = 1'b0;
    repeat (2) @(negedge clk);
    wr(2, EDR, 32'h40);
    rd("R8 set wins over clear", 2, EDR, 32'h40);
    wr(2, EDR, 32'h40);
    rd("R8 later clear works", 2, EDR, 0);
    wr(2, REN, 0); wr(2, FEN, 0);
  endtask

  task automatic t_mask();
    wr(3, REN, 32'h10);
    pins[100] = 1'b1; settle();
    rd("R9 status sets while masked", 3, EDR, 32'h10);
    chk("R9 shared low while masked", {31'd0, irq_shared}, 0);
    wr(3, MSK, 32'h10);
    #1;
    chk("R10 shared high unmasked", {31'd0, irq_shared}, 1);
    chk("R10 pin0/pin1 quiet", {30'd0, irq_pin0, irq_pin1}, 0);
    wr(3, EDR, 32'h10);
    #1;
    chk("R10 shared drops on clear", {31'd0, irq_shared}, 0);
    wr(3, MSK, 0); wr(3, REN, 0); pins[100] = 1'b0; settle();
  endtask

  task automatic t_irq();
    wr(0, REN, 32'h7); wr(0, MSK, 32'h7);
    pins[0] = 1'b1; settle();
    chk("R10 pin0 own line", {29'd0, irq_pin0, irq_pin1, irq_shared}, 3'b100);
    pins[1] = 1'b1; settle();
    chk("R10 pin1 own line", {29'd0, irq_pin0, irq_pin1, irq_shared}, 3'b110);
    pins[2] = 1'b1; settle();
    chk("R10 pin2 shared", {29'd0, irq_pin0, irq_pin1, irq_shared}, 3'b111);
    wr(0, EDR, 32'h1);
    #1;
    chk("R10 pin0 drops alone", {29'd0, irq_pin0, irq_pin1, irq_shared}, 3'b011);
    wr(0, EDR, 32'h6); wr(0, REN, 0); wr(0, MSK, 0);
    pins[2:0] = '0; settle();
  endtask

  task automatic t_dirout();
    wr(0, REN, 32'h100); wr(0, DSET, 32'h100);
    pins[8] = 1'b1; settle();
    rd("R11 output pin ignored", 0, EDR, 0);
    pins[8] = 1'b0; settle();
    wr(0, DCLR, 32'h100);
    settle();
    pins[8] = 1'b1; settle();
    rd("R11 input again detects", 0, EDR, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_map(); t_dir(); t_rise(); t_w1c(); t_fall();
    t_both(); t_setwins(); t_mask(); t_irq(); t_dirout();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule